// File: doc/BRIEF.md
# Smart-Card Application Header Parser

This block sits behind a frame receiver on a smart-card link and takes one frame payload at a time as a byte stream. A start marker opens the frame and an end marker closes it. The payload opens with a chain of interface control bytes of variable length, followed by a fixed three-byte application header and then a data body. The parser walks the control chain, records how many control bytes it saw, and decodes the dynamic buffer-size field carried by the second control byte. It then captures the header: the command/response flag, the class code or response status bitmap, the instruction or application status byte, and the declared data length.

Body bytes are forwarded one cycle after they arrive, each tagged with its index in the body. When the end marker arrives, a single result strobe presents every decoded field together with error flags for a frame that is too short, an unsupported length, and a length that does not match the body. The result fields hold their values until the next strobe. A new start marker always abandons the frame in progress.

Top module: `ahp_app_parser`

## Requirements
- R1: While in the control chain, a byte whose bit 7 is set means another control byte follows, and the first byte with bit 7 clear is the last control byte. Bits other than bit 7 are not examined on the first byte or on the third and later bytes. The result reports the number of control bytes (saturating at 2^CTL_W-1) and the body offset, which equals that number plus 3.
- R2: In the second control byte, bit 4 is the dynamic-buffer flag and bits 3:0 are the size field. With the flag set, the result reports the flag as 1 and the buffer size as field x 8. If the flag is clear, or if the chain has fewer than two bytes, both read 0.
- R3: Header byte 0 gives the response flag in bit 7 (0 = command, 1 = response) and the class code or status bitmap in bits 6:0. Header byte 1 is the instruction or application status byte. Header byte 2 is the data length.
- R4: A length of 255 raises the unsupported-length error, and none of that frame's body bytes are forwarded.
- R5: If the length is not 255 and differs from the number of body bytes received, the length-mismatch error is raised.
- R6: A frame that ends before all three header bytes have arrived raises the too-short error. Header fields that did not arrive read 0.
- R7: For a response, the reserved flags report bits 5:3 of header byte 0. For a command they read 0.
- R8: Each body byte appears on the body output one cycle after it is accepted, with an index that starts at 0 and rises by one per byte. At most 2^IDX_W bytes are forwarded, and each is counted toward the length check.
- R9: Exactly one result strobe is produced per completed frame, in the cycle after the end-marker byte. The result fields change only with that strobe, and at most one error flag is set.
- R10: Synchronous reset clears every output. A start marker aborts any frame in progress, and that frame produces no result. Bytes that arrive outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Input byte |
| body_valid | output | 1 | Forwarded body byte valid |
| body_data | output | 8 | Forwarded body byte |
| body_idx | output | IDX_W | Index of the body byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_resp | output | 1 | 1 = response, 0 = command |
| res_code | output | 7 | Class code or status bitmap |
| res_ins | output | 8 | Instruction or application status |
| res_len | output | 8 | Declared data length |
| res_ctl_cnt | output | CTL_W | Number of control bytes |
| res_body_off | output | CTL_W+1 | Offset of the body in the frame |
| res_buf_en | output | 1 | Dynamic buffer size present |
| res_buf_size | output | BFW+3 | Dynamic buffer size in bytes |
| res_resv | output | 3 | Reserved status bits seen set |
| err_short | output | 1 | Frame too short |
| err_len255 | output | 1 | Unsupported length 255 |
| err_len_mismatch | output | 1 | Length differs from body size |

## Verification
Whenever a frame ends on a body byte, the forwarded final body byte and the result strobe appear in the same cycle. Back-to-back frames with no idle gap also put one frame's strobe next to the next frame's control bytes. The scoreboard marks each expected result with whether its last body byte must share the strobe cycle. In that same cycle the monitor then compares the body output with the popped body item and with that mark. Frames are sent both with idle gaps and back to back, with bodies ending exactly on length, short or long.

// File: rtl/ahp_pkg.sv
package ahp_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTL,
    PH_H0,
    PH_H1,
    PH_H2,
    PH_BODY
  } ahp_phase_e;

  localparam logic [DW-1:0] LEN_UNSUPPORTED = 8'hFF;

endpackage

// File: rtl/ahp_ctl_chain.sv
module ahp_ctl_chain #(
  parameter int CTL_W = 4,
  parameter int BFW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [CTL_W-1:0] cnt_incl,
  output logic             buf_en_incl,
  output logic [BFW-1:0]   buf_fld_incl
);
  localparam logic [CTL_W-1:0] CNT_MAX = {CTL_W{1'b1}};
  localparam int BUF_FLAG_BIT = 4;

  logic [CTL_W-1:0] cnt_q;
  logic             buf_en_q;
  logic [BFW-1:0]   buf_fld_q;
  logic [CTL_W-1:0] cnt_base;
  logic             second;

  always_comb begin
    cnt_base = first ? '0 : cnt_q;
    second   = take && (cnt_base == CTL_W'(1));
    if (take)
      cnt_incl = (cnt_base == CNT_MAX) ? CNT_MAX : cnt_base + 1'b1;
    else
      cnt_incl = cnt_base;
    if (second) begin
      buf_en_incl  = data[BUF_FLAG_BIT];
      buf_fld_incl = data[BFW-1:0];
    end else if (first) begin
      buf_en_incl  = 1'b0;
      buf_fld_incl = '0;
    end else begin
      buf_en_incl  = buf_en_q;
      buf_fld_incl = buf_fld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      buf_en_q  <= 1'b0;
      buf_fld_q <= '0;
    end else if (take) begin
      cnt_q     <= cnt_incl;
      buf_en_q  <= buf_en_incl;
      buf_fld_q <= buf_fld_incl;
    end
  end

  AST_BUF_FROM_SECOND: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_en_q) |-> (cnt_q == CTL_W'(2))); // R2

endmodule

// File: rtl/ahp_body_tap.sv
module ahp_body_tap #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             clear,
  input  logic             pass_en,
  input  logic [7:0]       data,
  output logic             vld,
  output logic [7:0]       dat,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W:0]   cnt_incl
);
  logic [IDX_W:0] cnt_q;
  logic           full;

  assign full = cnt_q[IDX_W];

  always_comb begin
    if (clear)
      cnt_incl = '0;
    else if (take && !full)
      cnt_incl = cnt_q + 1'b1;
    else
      cnt_incl = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      vld   <= 1'b0;
      dat   <= '0;
      idx   <= '0;
    end else begin
      cnt_q <= cnt_incl;
      vld   <= take && pass_en && !full;
      if (take && pass_en && !full) begin
        dat <= data;
        idx <= cnt_q[IDX_W-1:0];
      end
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (vld && $past(vld)) |-> (idx == $past(idx) + 1'b1)); // R8

endmodule

// File: rtl/ahp_result_hold.sv
module ahp_result_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [W-1:0] d,
  output logic         strobe,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe <= 1'b0;
      q      <= '0;
    end else begin
      strobe <= fire;
      if (fire) q <= d;
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> $stable(q)); // R9

endmodule

// File: rtl/ahp_app_parser.sv
module ahp_app_parser
  import ahp_pkg::*;
#(
  parameter int CTL_W = 4,
  parameter int BFW   = 4,
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [7:0]         in_data,
  output logic               body_valid,
  output logic [7:0]         body_data,
  output logic [IDX_W-1:0]   body_idx,
  output logic               res_valid,
  output logic               res_resp,
  output logic [6:0]         res_code,
  output logic [7:0]         res_ins,
  output logic [7:0]         res_len,
  output logic [CTL_W-1:0]   res_ctl_cnt,
  output logic [CTL_W:0]     res_body_off,
  output logic               res_buf_en,
  output logic [BFW+2:0]     res_buf_size,
  output logic [2:0]         res_resv,
  output logic               err_short,
  output logic               err_len255,
  output logic               err_len_mismatch
);
  localparam int OFF_W = CTL_W + 1;
  localparam int BSZ_W = BFW + 3;
  localparam int RW    = 1 + 7 + 8 + 8 + CTL_W + OFF_W + 1 + BSZ_W + 3 + 3;

  ahp_phase_e phase_q, cur;
  logic start, live, fire;
  logic take_ctl, take_body;

  logic       resp_q;
  logic [6:0] code_q;
  logic [7:0] ins_q, len_q;

  logic       resp_i;
  logic [6:0] code_i;
  logic [7:0] ins_i, len_i;

  logic [CTL_W-1:0] cnt_i;
  logic             bufen_i;
  logic [BFW-1:0]   fld_i;
  logic [IDX_W:0]   nbody_i;

  logic [OFF_W-1:0] off_i;
  logic [BSZ_W-1:0] bsz_i;
  logic [2:0]       resv_i;
  logic             es_i, el_i, em_i;
  logic [RW-1:0]    res_d, res_q;

  // Input qualification and phase of the current byte
  assign start     = in_valid && in_sof;
  assign cur       = start ? PH_CTL : phase_q;
  assign live      = in_valid && (cur != PH_IDLE);
  assign fire      = live && in_eof;
  assign take_ctl  = live && (cur == PH_CTL);
  assign take_body = live && (cur == PH_BODY);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else if (live) begin
      if (in_eof) begin
        phase_q <= PH_IDLE;
      end else begin
        unique case (cur)
          PH_CTL:  phase_q <= in_data[7] ? PH_CTL : PH_H0;
          PH_H0:   phase_q <= PH_H1;
          PH_H1:   phase_q <= PH_H2;
          PH_H2:   phase_q <= PH_BODY;
          PH_BODY: phase_q <= PH_BODY;
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  // Header capture
  always_ff @(posedge clk) begin
    if (rst || start) begin
      resp_q <= 1'b0;
      code_q <= '0;
      ins_q  <= '0;
      len_q  <= '0;
    end else if (live) begin
      if (cur == PH_H0) begin
        resp_q <= in_data[7];
        code_q <= in_data[6:0];
      end
      if (cur == PH_H1) ins_q <= in_data;
      if (cur == PH_H2) len_q <= in_data;
    end
  end

  // Header view that includes the byte accepted this cycle
  always_comb begin
    resp_i = start ? 1'b0 : resp_q;
    code_i = start ? '0 : code_q;
    ins_i  = start ? '0 : ins_q;
    len_i  = start ? '0 : len_q;
    if (live && cur == PH_H0) begin
      resp_i = in_data[7];
      code_i = in_data[6:0];
    end
    if (live && cur == PH_H1) ins_i = in_data;
    if (live && cur == PH_H2) len_i = in_data;
  end

  ahp_ctl_chain #(.CTL_W(CTL_W), .BFW(BFW)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .take         (take_ctl),
    .first        (start),
    .data         (in_data),
    .cnt_incl     (cnt_i),
    .buf_en_incl  (bufen_i),
    .buf_fld_incl (fld_i)
  );

  ahp_body_tap #(.IDX_W(IDX_W)) u_body (
    .clk      (clk),
    .rst      (rst),
    .take     (take_body),
    .clear    (start),
    .pass_en  (len_q != LEN_UNSUPPORTED),
    .data     (in_data),
    .vld      (body_valid),
    .dat      (body_data),
    .idx      (body_idx),
    .cnt_incl (nbody_i)
  );

  // Result evaluation at the end marker
  always_comb begin
    off_i  = OFF_W'(cnt_i) + OFF_W'(3);
    bsz_i  = bufen_i ? {fld_i, 3'b000} : '0;
    resv_i = resp_i ? code_i[5:3] : 3'b000;
    es_i   = (cur == PH_CTL) || (cur == PH_H0) || (cur == PH_H1);
    el_i   = !es_i && (len_i == LEN_UNSUPPORTED);
    em_i   = !es_i && !el_i && (32'(nbody_i) != 32'(len_i));
    res_d  = {resp_i, code_i, ins_i, len_i, cnt_i, off_i, bufen_i, bsz_i,
              resv_i, es_i, el_i, em_i};
  end

  ahp_result_hold #(.W(RW)) u_res (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .d      (res_d),
    .strobe (res_valid),
    .q      (res_q)
  );

  assign {res_resp, res_code, res_ins, res_len, res_ctl_cnt, res_body_off,
          res_buf_en, res_buf_size, res_resv, err_short, err_len255,
          err_len_mismatch} = res_q;

  AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && in_eof)); // R9
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones({err_short, err_len255, err_len_mismatch}) <= 1)); // R9
  AST_NO_BODY_AT_255: assert property (@(posedge clk) disable iff (rst)
    body_valid |-> ($past(len_q) != LEN_UNSUPPORTED)); // R4
  AST_OFFSET: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_body_off == OFF_W'(res_ctl_cnt) + OFF_W'(3))); // R1
  AST_CMD_NO_RESV: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_resp) |-> (res_resv == 3'b000)); // R7

endmodule

// File: tb/sim_ahp_app_parser.sv
module sim_ahp_app_parser;
  typedef logic [7:0] bq_t[$];
  typedef struct packed {
    logic       resp;
    logic [6:0] code;
    logic [7:0] ins;
    logic [7:0] len;
    logic [3:0] ctl;
    logic [4:0] off;
    logic       bufen;
    logic [6:0] bufsz;
    logic [2:0] resv;
    logic       es, el, em;
    logic       co;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic body_valid;
  logic [7:0] body_data;
  logic [7:0] body_idx;
  logic res_valid, res_resp;
  logic [6:0] res_code;
  logic [7:0] res_ins, res_len;
  logic [3:0] res_ctl_cnt;
  logic [4:0] res_body_off;
  logic res_buf_en;
  logic [6:0] res_buf_size;
  logic [2:0] res_resv;
  logic err_short, err_len255, err_len_mismatch;

  int n_chk = 0, n_fail = 0, cyc = 0;
  exp_t exp_q[$];
  logic [15:0] body_q[$];
  exp_t last_e;

  always #5 clk = ~clk;

  ahp_app_parser u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .body_valid(body_valid),
    .body_data(body_data), .body_idx(body_idx), .res_valid(res_valid),
    .res_resp(res_resp), .res_code(res_code), .res_ins(res_ins),
    .res_len(res_len), .res_ctl_cnt(res_ctl_cnt), .res_body_off(res_body_off),
    .res_buf_en(res_buf_en), .res_buf_size(res_buf_size), .res_resv(res_resv),
    .err_short(err_short), .err_len255(err_len255),
    .err_len_mismatch(err_len_mismatch)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  task automatic cmp_fields(input string tag, input exp_t e);
    chk("R3", {tag, " resp"}, res_resp, e.resp);
    chk("R3", {tag, " code"}, res_code, e.code);
    chk("R3", {tag, " ins"}, res_ins, e.ins);
    chk("R3", {tag, " len"}, res_len, e.len);
    chk("R1", {tag, " ctl count"}, res_ctl_cnt, e.ctl);
    chk("R1", {tag, " body offset"}, res_body_off, e.off);
    chk("R2", {tag, " buf flag"}, res_buf_en, e.bufen);
    chk("R2", {tag, " buf size"}, res_buf_size, e.bufsz);
    chk("R7", {tag, " reserved"}, res_resv, e.resv);
    chk("R6", {tag, " short"}, err_short, e.es);
    chk("R4", {tag, " len255"}, err_len255, e.el);
    chk("R5", {tag, " mismatch"}, err_len_mismatch, e.em);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (body_valid) begin
        if (body_q.size() == 0) begin
          chk("R8", "unexpected body byte", 1, 0);
        end else begin
          logic [15:0] b;
          b = body_q.pop_front();
          chk("R8", "body index", body_idx, b[15:8]);
          chk("R8", "body data", body_data, b[7:0]);
        end
      end
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          chk("R10", "unexpected result strobe", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          cmp_fields("result", e);
          chk("R9", "body and result same cycle", body_valid, e.co);
          last_e = e;
        end
      end
    end
  end

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
  endtask

  // Driver: model the frame, push expectations, then drive it
  task automatic send_frame(input bq_t b);
    exp_t e;
    int ph, nb;
    logic lastpass;
    logic [7:0] v;
    e = '0; ph = 0; nb = 0; lastpass = 1'b0;
    foreach (b[i]) begin
      v = b[i];
      lastpass = 1'b0;
      case (ph)
        0: begin
          if (e.ctl != 4'hF) e.ctl = e.ctl + 1;
          if (e.ctl == 2) begin e.bufen = v[4]; e.bufsz = v[4] ? {v[3:0], 3'b000} : 7'd0; end
          if (!v[7]) ph = 1;
        end
        1: begin e.resp = v[7]; e.code = v[6:0]; ph = 2; end
        2: begin e.ins = v; ph = 3; end
        3: begin e.len = v; ph = 4; end
        default: begin
          if (e.len != 8'hFF && nb < 256) begin
            body_q.push_back({8'(nb), v});
            lastpass = 1'b1;
          end
          nb++;
        end
      endcase
    end
    e.off  = 5'(e.ctl) + 5'd3;
    e.resv = e.resp ? e.code[5:3] : 3'b000;
    e.es   = (ph < 4);
    e.el   = !e.es && (e.len == 8'hFF);
    e.em   = !e.es && !e.el && (nb != int'(e.len));
    e.co   = lastpass;
    exp_q.push_back(e);
    foreach (b[i]) put(b[i], i == 0, i == b.size() - 1);
  endtask

  task automatic drain;
    for (int i = 0; i < 50 && (exp_q.size() != 0 || body_q.size() != 0); i++) idle(1);
    idle(2);
  endtask

  initial begin
    bq_t f;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset res_valid", res_valid, 0);
    chk("R10", "reset body_valid", body_valid, 0);
    chk("R10", "reset fields", {res_ctl_cnt, res_len, err_short, err_len_mismatch}, 0);
    rst = 1'b0;
    idle(2);

    // Command, two control bytes, dynamic buffer flag, exact length
    f = '{8'h85, 8'h1A, 8'h05, 8'h12, 8'h03, 8'hA1, 8'hA2, 8'hA3};
    send_frame(f); idle(3);

    // Response, one control byte, reserved bits set, zero length
    f = '{8'h01, 8'hB9, 8'h2C, 8'h00};
    send_frame(f); idle(2);

    // Three control bytes, flag with zero field, long body -> mismatch (R5)
    f = '{8'h80, 8'h90, 8'h07, 8'h06, 8'h33, 8'h02, 8'h11, 8'h22, 8'h33, 8'h44};
    send_frame(f); idle(2);

    // Length 255, body not forwarded (R4)
    f = '{8'h00, 8'h06, 8'h40, 8'hFF, 8'h55, 8'h66};
    send_frame(f); idle(2);

    // Short frames (R6): chain only, and one header byte
    f = '{8'h80};
    send_frame(f); idle(1);
    f = '{8'h00, 8'hC4};
    send_frame(f); idle(2);

    // Body shorter than declared length (R5), second ctl without flag (R2)
    f = '{8'h81, 8'h6F, 8'h02, 8'h10, 8'h05, 8'hE0};
    send_frame(f); idle(2);

    // Junk outside a frame, then an aborted frame, then a full one (R10)
    put(8'h3C, 1'b0, 1'b0); put(8'h9A, 1'b0, 1'b1); idle(2);
    put(8'h00, 1'b1, 1'b0); put(8'h05, 1'b0, 1'b0);
    f = '{8'h02, 8'hA8, 8'h77, 8'h01, 8'h5E};
    send_frame(f); idle(2);

    // Back-to-back frames without gap
    f = '{8'h00, 8'h01, 8'h02, 8'h01, 8'hC3};
    send_frame(f);
    f = '{8'h00, 8'h81, 8'h09, 8'h00};
    send_frame(f); idle(2);

    // Long body beyond the forward limit (R8)
    f = '{8'h00, 8'h03, 8'h04, 8'h00};
    for (int i = 0; i < 258; i++) f.push_back(8'(i * 7));
    send_frame(f);
    drain();

    // R9: fields hold after the strobe while idle and while junk arrives
    idle(4);
    put(8'h11, 1'b0, 1'b1); idle(3);
    cmp_fields("R9 hold", last_e);
    chk("R9", "no extra strobe", res_valid, 0);
    chk("R8", "expected body bytes consumed", body_q.size(), 0);
    chk("R9", "expected results consumed", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule